// File: doc/BRIEF.md
# Transmit Robbed-Bit Signaling Inserter

This block sits in the transmit path of a 24-channel T1 framer. It carries four signaling bits (A, B, C, D) for each voice channel into the outgoing serial PCM stream. A host fills a bank of byte-wide registers. At each load point the block copies the whole bank into a shadow register. From there it overwrites the least significant bit of every channel byte in the robbed frames of the multiframe. Host writes made after a load therefore never disturb the multiframe that is being sent. Each load sets a sticky interrupt flag, which gives the host a full load interval to write the next values.

Two framing modes are supported. In the four-bit mode the multiframe has 24 frames and the bank is loaded at every boundary. In the two-bit mode the multiframe has 12 frames and each one carries only A and B. The bank then holds two multiframes' worth of bits: the third and fourth register groups supply A and B for the second multiframe, and a load happens only at every other boundary. The stream is one bit per clock. A frame is 193 bits long: one framing bit, then 24 channel bytes sent MSB first. The output is registered, so `ser_out` lags `ser_in` by one clock.

A small state machine tracks the load phase:
- `PH_HUNT`: reset state, the block is not aligned.
- `PH_FIRST`: a load has just been taken.
- `PH_SECOND`: second multiframe of a two-bit pair, with no load at its start.

Its transitions are:
- ACQUIRE: `PH_HUNT` to `PH_FIRST` on the first multiframe sync, with a load.
- RELOAD: to `PH_FIRST` at a boundary, with a load. This is taken from `PH_FIRST` in four-bit mode and from `PH_SECOND` in either mode.
- ADVANCE: `PH_FIRST` to `PH_SECOND` at a boundary in two-bit mode, with no load.

A boundary is a framing bit whose frame index is 0. It is reached either by the multiframe sync or by the frame counter wrapping.

Top module: `tx_robbed_sig`

## Requirements
- R1: After reset, `ser_out` and `mf_irq` are 0, every register reads 0 and the phase is `PH_HUNT`.
- R2: Register address `a` (0..11) holds group `a/3` for channels `(a%3)*8+1` to `(a%3)*8+8`. Bit `j` belongs to channel `(a%3)*8+j+1`. Groups are 0=A, 1=B, 2=A/C, 3=B/D. Registers read back what was written.
- R3: `ser_out` equals `ser_in` delayed by one clock in every bit position except robbed ones. Robbed positions are bit 7 (the last, least significant bit) of each channel byte in frames whose 0-based index mod 6 equals 5. The framing bit is never changed.
- R4: In four-bit mode (`d4_mode`=0) frames 5, 11, 17 and 23 (0-based) carry groups 0, 1, 2 and 3 respectively.
- R5: In two-bit mode (`d4_mode`=1) frames 5 and 11 carry groups 0 and 1 in the multiframe that starts with a load. In the following multiframe they carry groups 2 and 3.
- R6: The shadow is loaded from the bank at every boundary in four-bit mode and at every other boundary in two-bit mode. A write that lands after a load affects only later loads.
- R7: With `tx_sig_en`=0 no bit is replaced. Loads and the interrupt still occur.
- R8: `mf_irq` is set by every load. It stays set until a write to address 12 with bit 0 = 1 clears it. A load in the same cycle wins over the clear. Address 12 reads `mf_irq` in bit 0.
- R9: Before the first `msync` after reset, no load occurs, no bit is replaced and `fsync` is ignored. That `msync` marks the framing bit of frame 0 and starts a load-bearing multiframe.
- R10: Once aligned, an `fsync` that arrives where no framing bit is expected restarts the bit count at a framing bit of the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one stream bit per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe |
| addr | input | AW (4) | Host register address, shared by read and write |
| wr_data | input | 8 | Host write data |
| rd_data | output | 8 | Read data for `addr` (combinational) |
| d4_mode | input | 1 | 1 = two-bit 12-frame mode, 0 = four-bit 24-frame mode |
| tx_sig_en | input | 1 | Enables replacement of robbed bits |
| ser_in | input | 1 | Incoming serial PCM bit |
| fsync | input | 1 | High on a framing bit |
| msync | input | 1 | High on the framing bit of frame 0 |
| ser_out | output | 1 | Outgoing serial PCM bit, one clock after `ser_in` |
| mf_irq | output | 1 | Sticky load interrupt flag |

## Verification
The bench builds the block with its default of 24 channels, so the bank is twelve registers and the status register sits at address 12. This puts every register chunk of every group, and the channel-to-bit mapping across all 24 channels, inside full-length 193-bit frames. The 24-frame and 12-frame multiframes are both run end to end. The cases covered are:
- the skipped load in two-bit mode;
- a write landing mid-multiframe;
- a truncated frame realigned by `fsync`.

// File: rtl/rbs_pkg.sv
package rbs_pkg;
    localparam int CH_BITS    = 8;
    localparam int SBW        = 3;
    localparam int FRW        = 5;
    localparam int FRAMES_ESF = 24;
    localparam int FRAMES_D4  = 12;
    localparam int ROB_STRIDE = 6;
    localparam int GROUPS     = 4;

    typedef enum logic [1:0] {
        PH_HUNT   = 2'd0,
        PH_FIRST  = 2'd1,
        PH_SECOND = 2'd2
    } phase_e;
endpackage

// File: rtl/rbs_regfile.sv
module rbs_regfile
    import rbs_pkg::*;
#(
    parameter int NUM_CH   = 24,
    parameter int NUM_REGS = NUM_CH * GROUPS / CH_BITS,
    parameter int AW       = $clog2(NUM_REGS + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [AW-1:0]              addr,
    input  logic [7:0]                 wr_data,
    output logic [7:0]                 rd_data,
    input  logic                       load,
    output logic [NUM_REGS*CH_BITS-1:0] bank_flat,
    output logic                       irq
);
    localparam int STATUS_ADDR = NUM_REGS;

    logic [7:0] regs_q [NUM_REGS];
    logic       irq_q;
    logic       clr;

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs_q[r] <= '0;
            end else if (wr_en && int'(addr) == r) begin
                regs_q[r] <= wr_data;
            end
        end
        assign bank_flat[r*CH_BITS +: CH_BITS] = regs_q[r];
    end

    assign clr = wr_en && (int'(addr) == STATUS_ADDR) && wr_data[0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else if (load) begin
            irq_q <= 1'b1;
        end else if (clr) begin
            irq_q <= 1'b0;
        end
    end

    always_comb begin
        rd_data = '0;
        if (int'(addr) < NUM_REGS) begin
            rd_data = regs_q[addr];
        end else if (int'(addr) == STATUS_ADDR) begin
            rd_data = {7'b0, irq_q};
        end
    end

    assign irq = irq_q;

    // R8: a load always leaves the flag set
    p_irq_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> irq_q);

    // R8: write-one-to-clear without a competing load empties the flag
    p_irq_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && int'(addr) == STATUS_ADDR && wr_data[0] && !load) |=> !irq_q);
endmodule

// File: rtl/rbs_frame_track.sv
module rbs_frame_track
    import rbs_pkg::*;
#(
    parameter int NUM_CH = 24,
    parameter int CHW    = $clog2(NUM_CH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           d4_mode,
    input  logic           fsync,
    input  logic           msync,
    output logic           load,
    output logic           slot_rob,
    output logic [1:0]     grp,
    output logic [CHW-1:0] ch_idx
);
    phase_e           phase_q, phase_d;
    logic             fbit_q;
    logic [CHW-1:0]   ch_q;
    logic [SBW-1:0]   sb_q;
    logic [FRW-1:0]   frm_q;

    logic             locked, run, boundary;
    logic             cur_fbit;
    logic [FRW-1:0]   cur_frm, last_frm, frm_inc;
    logic [1:0]       quarter;

    assign locked   = (phase_q != PH_HUNT);
    assign run      = locked || msync;
    assign last_frm = d4_mode ? FRW'(FRAMES_D4 - 1) : FRW'(FRAMES_ESF - 1);
    assign frm_inc  = (frm_q >= last_frm) ? '0 : frm_q + 1'b1;

    // position of the bit presented in this cycle
    always_comb begin
        cur_fbit = fbit_q;
        cur_frm  = frm_q;
        if (msync) begin
            cur_fbit = 1'b1;
            cur_frm  = '0;
        end else if (locked && fsync && !fbit_q) begin
            cur_fbit = 1'b1;
            cur_frm  = frm_inc;
        end
    end

    assign boundary = run && cur_fbit && (cur_frm == '0);

    // bit, channel and frame counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fbit_q <= 1'b1;
            ch_q   <= '0;
            sb_q   <= '0;
            frm_q  <= '0;
        end else if (run) begin
            if (cur_fbit) begin
                fbit_q <= 1'b0;
                ch_q   <= '0;
                sb_q   <= '0;
                frm_q  <= cur_frm;
            end else if (sb_q == SBW'(CH_BITS - 1)) begin
                sb_q <= '0;
                if (ch_q == CHW'(NUM_CH - 1)) begin
                    ch_q   <= '0;
                    fbit_q <= 1'b1;
                    frm_q  <= frm_inc;
                end else begin
                    ch_q <= ch_q + 1'b1;
                end
            end else begin
                sb_q <= sb_q + 1'b1;
            end
        end
    end

    // phase state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_HUNT;
        end else begin
            phase_q <= phase_d;
        end
    end

    // next phase and load strobe
    always_comb begin
        phase_d = phase_q;
        load    = 1'b0;
        unique case (phase_q)
            PH_HUNT: begin
                if (msync) begin
                    phase_d = PH_FIRST;
                    load    = 1'b1;
                end
            end
            PH_FIRST: begin
                if (boundary) begin
                    if (d4_mode) begin
                        phase_d = PH_SECOND;
                    end else begin
                        load = 1'b1;
                    end
                end
            end
            PH_SECOND: begin
                if (boundary) begin
                    phase_d = PH_FIRST;
                    load    = 1'b1;
                end
            end
            default: begin
                phase_d = PH_HUNT;
            end
        endcase
    end

    // robbed slot selection
    assign quarter  = 2'(int'(cur_frm) / ROB_STRIDE);
    assign slot_rob = locked && !cur_fbit && (sb_q == SBW'(CH_BITS - 1))
                      && ((int'(cur_frm) % ROB_STRIDE) == ROB_STRIDE - 1);
    assign grp      = d4_mode ? {phase_q == PH_SECOND, quarter[0]} : quarter;
    assign ch_idx   = ch_q;

    // R9: nothing is loaded or replaced while hunting
    p_hunt_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_HUNT && !msync) |-> (!load && !slot_rob));

    // R9: alignment, once gained, is kept until reset
    p_stay_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q != PH_HUNT) |=> (phase_q != PH_HUNT));

    // R6: every load starts a first-half multiframe
    p_load_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (phase_q == PH_FIRST));
endmodule

// File: rtl/rbs_inserter.sv
module rbs_inserter
    import rbs_pkg::*;
#(
    parameter int NUM_CH = 24,
    parameter int CHW    = $clog2(NUM_CH)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load,
    input  logic [GROUPS*NUM_CH-1:0]   bank_flat,
    input  logic                       slot_rob,
    input  logic [1:0]                 grp,
    input  logic [CHW-1:0]             ch_idx,
    input  logic                       tx_en,
    input  logic                       ser_in,
    output logic                       ser_out
);
    localparam int SHW = GROUPS * NUM_CH;
    localparam int IW  = $clog2(SHW);

    logic [SHW-1:0] shadow_q;
    logic [IW-1:0]  sel;
    logic           sig_bit;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= '0;
        end else if (load) begin
            shadow_q <= bank_flat;
        end
    end

    assign sel     = IW'(grp) * IW'(NUM_CH) + IW'(ch_idx);
    assign sig_bit = shadow_q[sel];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ser_out <= 1'b0;
        end else begin
            ser_out <= (tx_en && slot_rob) ? sig_bit : ser_in;
        end
    end

    // R7: with insertion disabled the stream is only delayed
    p_passthru_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> (ser_out == $past(ser_in)));

    // R3: only robbed slots may differ from the input
    p_rob_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_rob |=> (ser_out == $past(ser_in)));
endmodule

// File: rtl/tx_robbed_sig.sv
module tx_robbed_sig
    import rbs_pkg::*;
#(
    parameter int NUM_CH = 24,
    parameter int AW     = $clog2(NUM_CH * GROUPS / CH_BITS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wr_data,
    output logic [7:0]    rd_data,
    input  logic          d4_mode,
    input  logic          tx_sig_en,
    input  logic          ser_in,
    input  logic          fsync,
    input  logic          msync,
    output logic          ser_out,
    output logic          mf_irq
);
    localparam int NUM_REGS = NUM_CH * GROUPS / CH_BITS;
    localparam int CHW      = $clog2(NUM_CH);

    logic                      load;
    logic                      slot_rob;
    logic [1:0]                grp;
    logic [CHW-1:0]            ch_idx;
    logic [GROUPS*NUM_CH-1:0]  bank_flat;

    rbs_regfile #(.NUM_CH(NUM_CH), .NUM_REGS(NUM_REGS), .AW(AW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .addr     (addr),
        .wr_data  (wr_data),
        .rd_data  (rd_data),
        .load     (load),
        .bank_flat(bank_flat),
        .irq      (mf_irq)
    );

    rbs_frame_track #(.NUM_CH(NUM_CH), .CHW(CHW)) u_track (
        .clk     (clk),
        .rst_n   (rst_n),
        .d4_mode (d4_mode),
        .fsync   (fsync),
        .msync   (msync),
        .load    (load),
        .slot_rob(slot_rob),
        .grp     (grp),
        .ch_idx  (ch_idx)
    );

    rbs_inserter #(.NUM_CH(NUM_CH), .CHW(CHW)) u_ins (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .bank_flat(bank_flat),
        .slot_rob (slot_rob),
        .grp      (grp),
        .ch_idx   (ch_idx),
        .tx_en    (tx_sig_en),
        .ser_in   (ser_in),
        .ser_out  (ser_out)
    );
endmodule

// File: tb/tb_tx_robbed_sig.sv
`timescale 1ns/1ps
module tb_tx_robbed_sig;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       d4_mode = 1'b0;
    logic       tx_sig_en = 1'b0;
    logic       ser_in = 1'b0;
    logic       fsync = 1'b0;
    logic       msync = 1'b0;
    logic       ser_out;
    logic       mf_irq;

    int checks = 0;
    int fails  = 0;
    int mism   = 0;
    logic [15:0] lf = 16'hACE1;
    logic [7:0]  bank   [12];
    logic [7:0]  loaded [12];

    always #2 clk = ~clk;

    tx_robbed_sig dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .d4_mode(d4_mode),
        .tx_sig_en(tx_sig_en), .ser_in(ser_in), .fsync(fsync),
        .msync(msync), .ser_out(ser_out), .mf_irq(mf_irq)
    );

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic nextbit();
        logic b;
        b  = lf[0];
        lf = {lf[0] ^ lf[2] ^ lf[3] ^ lf[5], lf[15:1]};
        return b;
    endfunction

    task automatic do_reset();
        rst_n = 1'b0; wr_en = 1'b0; ser_in = 1'b0; msync = 1'b0; fsync = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 12; i++) begin
            bank[i] = '0; loaded[i] = '0;
        end
    endtask

    // single-cycle host write, only used while the stream is not aligned
    task automatic host_wr(input int a, input logic [7:0] d);
        wr_en = 1'b1; addr = 4'(a); wr_data = d;
        @(posedge clk); #1 wr_en = 1'b0;
        @(negedge clk);
        if (a < 12) bank[a] = d;
    endtask

    task automatic fill_bank(input logic [7:0] seed);
        for (int r = 0; r < 12; r++) host_wr(r, 8'(seed + 8'(r * 37)) ^ 8'(r << 4));
    endtask

    task automatic drive_bit(input logic d, input logic ms, input logic fs,
                             input logic ex, input bit chk_en);
        ser_in = d; msync = ms; fsync = fs;
        @(posedge clk);
        #1 wr_en = 1'b0;
        @(negedge clk);
        if (chk_en && ser_out !== ex) mism++;
    endtask

    // one multiframe; expected bits come from the model snapshot
    task automatic send_mf(input bit d4, input bit half, input bit sync,
                           input bit ld, input bit ins, input int trunc,
                           input bit do_wr, input int wr_f, input int wa,
                           input logic [7:0] wd);
        int nf;
        int nbits;
        int g;
        logic d;
        logic ex;
        nf = d4 ? 12 : 24;
        mism = 0;
        if (ld) for (int i = 0; i < 12; i++) loaded[i] = bank[i];
        for (int f = 0; f < nf; f++) begin
            if (do_wr && f == wr_f && f != 0) begin
                wr_en = 1'b1; addr = 4'(wa); wr_data = wd;
                if (wa < 12) bank[wa] = wd;
            end
            d = nextbit();
            drive_bit(d, sync && f == 0, 1'b1, d, 1'b1);
            nbits = (f == 0) ? trunc : 192;
            for (int p = 0; p < nbits; p++) begin
                d  = nextbit();
                ex = d;
                if (ins && (p % 8) == 7 && (f % 6) == 5) begin
                    g  = d4 ? (f / 6 + 2 * int'(half)) : f / 6;
                    ex = loaded[g * 3 + (p / 8) / 8][(p / 8) % 8];
                end
                drive_bit(d, 1'b0, 1'b0, ex, 1'b1);
            end
        end
    endtask

    task automatic t_reset();
        logic [7:0] v;
        int bad;
        do_reset();
        chk(ser_out === 1'b0, "R1", "ser_out after reset", int'(ser_out), 0);
        chk(mf_irq === 1'b0, "R1", "mf_irq after reset", int'(mf_irq), 0);
        bad = 0;
        for (int a = 0; a < 13; a++) begin
            addr = 4'(a); #1 v = rd_data;
            if (v !== 8'h00) bad++;
        end
        chk(bad == 0, "R1", "registers not zero", bad, 0);
    endtask

    task automatic t_regmap();
        logic [7:0] v;
        do_reset();
        fill_bank(8'h3C);
        for (int a = 0; a < 12; a++) begin
            addr = 4'(a); #1 v = rd_data;
            chk(v === bank[a], "R2", $sformatf("readback addr %0d", a), int'(v), int'(bank[a]));
        end
    endtask

    task automatic t_hunt();
        do_reset();
        d4_mode = 1'b0; tx_sig_en = 1'b1;
        fill_bank(8'hA5);
        send_mf(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 192, 1'b0, 0, 0, 8'h00);
        chk(mism == 0, "R9", "bits changed before alignment", mism, 0);
        chk(mf_irq === 1'b0, "R9", "irq before alignment", int'(mf_irq), 0);
    endtask

    task automatic t_esf();
        do_reset();
        d4_mode = 1'b0; tx_sig_en = 1'b1;
        fill_bank(8'h5A);
        send_mf(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 192, 1'b0, 0, 0, 8'h00);
        chk(mism == 0, "R4", "four-bit mf1 mismatches (R2 R3 mapping)", mism, 0);
        chk(mf_irq === 1'b1, "R8", "irq set by load", int'(mf_irq), 1);
        send_mf(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 192, 1'b1, 2, 0, 8'hC3);
        chk(mism == 0, "R6", "mid-mf write leaked into current mf", mism, 0);
        chk(mf_irq === 1'b1, "R8", "irq stays set", int'(mf_irq), 1);
        send_mf(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 192, 1'b1, 2, 12, 8'h01);
        chk(mism == 0, "R6", "next load carries new write", mism, 0);
        chk(mf_irq === 1'b0, "R8", "irq cleared by write one", int'(mf_irq), 0);
        send_mf(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 192, 1'b0, 0, 0, 8'h00);
        chk(mism == 0, "R4", "four-bit mf4 mismatches", mism, 0);
        chk(mf_irq === 1'b1, "R6", "every four-bit boundary loads", int'(mf_irq), 1);
    endtask

    task automatic t_d4();
        do_reset();
        d4_mode = 1'b1; tx_sig_en = 1'b1;
        fill_bank(8'h96);
        send_mf(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 192, 1'b1, 2, 12, 8'h01);
        chk(mism == 0, "R5", "two-bit first half", mism, 0);
        chk(mf_irq === 1'b0, "R8", "irq cleared", int'(mf_irq), 0);
        send_mf(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 192, 1'b1, 2, 0, 8'h0F);
        chk(mism == 0, "R5", "two-bit second half uses C/D groups", mism, 0);
        chk(mf_irq === 1'b0, "R6", "no load on second half", int'(mf_irq), 0);
        send_mf(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 192, 1'b0, 0, 0, 8'h00);
        chk(mism == 0, "R5", "two-bit reload with new value", mism, 0);
        chk(mf_irq === 1'b1, "R6", "load every other boundary", int'(mf_irq), 1);
    endtask

    task automatic t_disable();
        do_reset();
        d4_mode = 1'b0; tx_sig_en = 1'b0;
        fill_bank(8'hE1);
        send_mf(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 192, 1'b0, 0, 0, 8'h00);
        chk(mism == 0, "R7", "bits changed while disabled", mism, 0);
        chk(mf_irq === 1'b1, "R7", "load still flags irq", int'(mf_irq), 1);
    endtask

    task automatic t_fsync();
        do_reset();
        d4_mode = 1'b0; tx_sig_en = 1'b1;
        fill_bank(8'h27);
        send_mf(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 192, 1'b0, 0, 0, 8'h00);
        send_mf(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 100, 1'b0, 0, 0, 8'h00);
        chk(mism == 0, "R10", "realign after short frame", mism, 0);
        send_mf(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 192, 1'b0, 0, 0, 8'h00);
        chk(mism == 0, "R10", "alignment held after realign", mism, 0);
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_regmap();
        t_hunt();
        t_esf();
        t_d4();
        t_disable();
        t_fsync();
        report();
        $finish;
    end
endmodule